// File: doc/BRIEF.md
# Reduced-Precision Float Codec

This block converts operand values between IEEE754 single precision and a family of narrower floating-point formats, so that a value can sit in a storage slot smaller than 32 bits. A 3-bit format code picks the target width per operand. The packer direction takes a single-precision word and produces the narrow encoding. It rebiases the exponent, rounds the mantissa to nearest-even, saturates to infinity, flushes small values to a signed zero and keeps NaN and infinity. The unpacker direction takes a narrow encoding and rebuilds a single-precision word, with the mantissa bits that the narrow format cannot hold set to zero.

Both directions are combinational and run side by side under the same format code. A parameter adds one output register stage, which is reset to zero. Narrow encodings are always right-aligned in a 32-bit word.

Top module: `fpn_codec`

## Requirements
- R1: Format codes select (total width, exponent bits, mantissa bits): 0 → (32,8,23), 1 → (28,7,20), 2 → (24,6,17), 3 → (20,5,14), 4 → (16,5,10), 5 → (12,4,7), 6 → (8,3,4). Code 7 behaves like code 0. Each narrow word is laid out as sign, then exponent, then mantissa, from high bit to low bit. The exponent bias is 2^(e-1)-1.
- R2: With code 0 or 7, both directions pass the 32-bit word through unchanged.
- R3: Packing a finite normal input rebiases the exponent from 127 to the target bias. It rounds the dropped mantissa bits to nearest, and a tie goes to an even result.
- R4: A rebiased exponent above 2^e-2 produces a signed infinity (exponent all ones, mantissa zero). So does a rounding carry that pushes the exponent to all ones. An infinite input packs to a signed infinity.
- R5: A NaN input packs to exponent all ones, with only the top mantissa bit set, and keeps its sign.
- R6: If the input exponent field is zero, or the rebiased exponent is below 1 before rounding, the result is a zero carrying the input sign.
- R7: The narrow result is right-aligned, and all bits at and above the total width are zero.
- R8: The sign of the input appears at bit position e+m of the packed word.
- R9: Unpacking rebiases the exponent back to 127 and left-aligns the mantissa into 23 bits with the low bits zero. A zero exponent field gives a signed zero. An all-ones exponent field gives exponent 255. Input bits at and above the total width are ignored.
- R10: With REG_OUT=1, both outputs change one clock after their inputs, and reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 3 | Format code shared by both directions |
| pack_data_i | input | 32 | Single-precision value to narrow |
| packed_o | output | 32 | Narrow encoding, right-aligned |
| unpack_data_i | input | 32 | Right-aligned narrow encoding to widen |
| unpacked_o | output | 32 | Rebuilt single-precision value |

## Verification
The assertions check the following on every evaluation: pass-through for the wide codes, the quiet-NaN shape, signed zero for zero or denormal inputs, sign placement, zeros above the narrow width, and cleared low mantissa bits after unpacking. Only the bench scenarios can show that rounding picks the right neighbour, including ties to even. The same holds for the rounding carry that tips into infinity, the exact underflow boundary, and the one-cycle output latency after reset. These are compared against a behavioural model on every clock.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  localparam int WORD_W = 32;
  localparam int SP_EXP = 8;
  localparam int SP_MAN = 23;
  localparam int SP_BIAS = 127;

  function automatic int exp_bits(input logic [2:0] code);
    case (code)
      3'd1: return 7;
      3'd2: return 6;
      3'd3: return 5;
      3'd4: return 5;
      3'd5: return 4;
      3'd6: return 3;
      default: return SP_EXP;
    endcase
  endfunction

  function automatic int man_bits(input logic [2:0] code);
    case (code)
      3'd1: return 20;
      3'd2: return 17;
      3'd3: return 14;
      3'd4: return 10;
      3'd5: return 7;
      3'd6: return 4;
      default: return SP_MAN;
    endcase
  endfunction
endpackage

// File: rtl/fpn_pack.sv
module fpn_pack
  import fpn_pkg::*;
(
  input  logic [2:0]        fmt_i,
  input  logic [WORD_W-1:0] val_i,
  output logic [WORD_W-1:0] pk_o
);
  logic        sgn;
  logic [7:0]  ein;
  logic [22:0] min;
  assign sgn = val_i[31];
  assign ein = val_i[30:23];
  assign min = val_i[22:0];

  always_comb begin
    int eb, mb, drop, bias, emax, enew;
    logic [31:0] mant_w, keep, emask, em, mag;
    logic rb, sb, inc;
    eb     = exp_bits(fmt_i);
    mb     = man_bits(fmt_i);
    drop   = SP_MAN - mb;
    bias   = (1 << (eb - 1)) - 1;
    emax   = (1 << eb) - 2;
    enew   = int'(ein) - SP_BIAS + bias;
    emask  = (32'd1 << eb) - 32'd1;
    mant_w = {9'b0, min};
    keep   = mant_w >> drop;
    rb     = (drop > 0) ? mant_w[drop-1] : 1'b0;
    sb     = (drop > 1) ? ((mant_w & ((32'd1 << (drop - 1)) - 32'd1)) != 32'd0) : 1'b0;
    inc    = rb & (sb | keep[0]);
    // rounding carry propagates into the exponent field and may yield inf
    em     = ((32'(enew) << mb) | keep) + {31'b0, inc};
    if (ein == 8'hff)
      mag = (emask << mb) | ((min != 23'd0) ? (32'd1 << (mb - 1)) : 32'd0);
    else if (ein == 8'd0 || enew < 1)
      mag = 32'd0;
    else if (enew > emax)
      mag = emask << mb;
    else
      mag = em;
    if (eb == SP_EXP) pk_o = val_i;
    else              pk_o = ({31'b0, sgn} << (eb + mb)) | mag;
  end

  always_comb begin
    int eb_a, mb_a;
    eb_a = exp_bits(fmt_i);
    mb_a = man_bits(fmt_i);
    if (eb_a == SP_EXP)
      AST_PASS_WIDE: assert (pk_o == val_i); // R2
    else begin
      AST_UPPER_CLEAR: assert ((pk_o >> (eb_a + mb_a + 1)) == 32'd0); // R7
      AST_SIGN_PLACE: assert (pk_o[eb_a+mb_a] == sgn); // R8
      if (ein == 8'hff && min != 23'd0)
        AST_QUIET_NAN: assert (((pk_o >> mb_a) & ((32'd1 << eb_a) - 32'd1)) == ((32'd1 << eb_a) - 32'd1)
                               && (pk_o & ((32'd1 << mb_a) - 32'd1)) == (32'd1 << (mb_a - 1))); // R5
      if (ein == 8'd0)
        AST_ZERO_FLUSH: assert ((pk_o & ((32'd1 << (eb_a + mb_a)) - 32'd1)) == 32'd0); // R6
    end
  end
endmodule

// File: rtl/fpn_unpack.sv
module fpn_unpack
  import fpn_pkg::*;
(
  input  logic [2:0]        fmt_i,
  input  logic [WORD_W-1:0] pk_i,
  output logic [WORD_W-1:0] val_o
);
  always_comb begin
    int eb, mb, bias;
    logic [31:0] emask, ex, mt, ml;
    logic sgn;
    eb    = exp_bits(fmt_i);
    mb    = man_bits(fmt_i);
    bias  = (1 << (eb - 1)) - 1;
    emask = (32'd1 << eb) - 32'd1;
    ex    = (pk_i >> mb) & emask;
    mt    = pk_i & ((32'd1 << mb) - 32'd1);
    ml    = mt << (SP_MAN - mb);
    sgn   = pk_i[eb+mb];
    if (eb == SP_EXP)    val_o = pk_i;
    else if (ex == 0)    val_o = {sgn, 31'b0};
    else if (ex == emask) val_o = {sgn, 8'hff, ml[22:0]};
    else                 val_o = {sgn, 8'(int'(ex) - bias + SP_BIAS), ml[22:0]};
  end

  always_comb begin
    int eb_a, mb_a;
    eb_a = exp_bits(fmt_i);
    mb_a = man_bits(fmt_i);
    if (eb_a != SP_EXP)
      AST_LOW_MANT_CLEAR: assert ((val_o & ((32'd1 << (SP_MAN - mb_a)) - 32'd1)) == 32'd0); // R9
  end
endmodule

// File: rtl/fpn_codec.sv
module fpn_codec
  import fpn_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        fmt_i,
  input  logic [WORD_W-1:0] pack_data_i,
  output logic [WORD_W-1:0] packed_o,
  input  logic [WORD_W-1:0] unpack_data_i,
  output logic [WORD_W-1:0] unpacked_o
);
  logic [WORD_W-1:0] pk_d, up_d;

  fpn_pack u_pack (
    .fmt_i (fmt_i),
    .val_i (pack_data_i),
    .pk_o  (pk_d)
  );

  fpn_unpack u_unpack (
    .fmt_i (fmt_i),
    .pk_i  (unpack_data_i),
    .val_o (up_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        packed_o   <= '0;
        unpacked_o <= '0;
      end else begin
        packed_o   <= pk_d;
        unpacked_o <= up_d;
      end
    end

    AST_WIDE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(fmt_i) == 3'd0) |-> packed_o == $past(pack_data_i)); // R10
  end else begin : g_comb
    assign packed_o   = pk_d;
    assign unpacked_o = up_d;
  end
endmodule

// File: tb/fpn_codec_tb_top.sv
module fpn_codec_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  fmt_i = 3'd0;
  logic [31:0] pack_data_i = 32'h0;
  logic [31:0] unpack_data_i = 32'h0;
  logic [31:0] packed_o, unpacked_o;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  fpn_codec dut_i (
    .clk_i, .rst_ni, .fmt_i, .pack_data_i, .packed_o, .unpack_data_i, .unpacked_o
  );

  function automatic void widths(input int code, output int e, output int m);
    int et[8] = '{8, 7, 6, 5, 5, 4, 3, 8};
    int mt[8] = '{23, 20, 17, 14, 10, 7, 4, 23};
    e = et[code];
    m = mt[code];
  endfunction

  function automatic logic [31:0] ref_pack(input int code, input logic [31:0] x);
    int e, m, bias, top, ne, d;
    longint s, ex, mn, k;
    widths(code, e, m);
    if (e == 8) return x;
    s = x[31]; ex = x[30:23]; mn = x[22:0];
    bias = 2 ** (e - 1) - 1;
    top = 2 ** e - 2;
    s = s << (e + m);
    if (ex == 255) begin
      if (mn != 0) return 32'(s + ((2 ** e - 1) << m) + (1 << (m - 1)));
      return 32'(s + ((2 ** e - 1) << m));
    end
    if (ex == 0) return 32'(s);
    ne = int'(ex) - 127 + bias;
    if (ne < 1) return 32'(s);
    if (ne > top) return 32'(s + ((2 ** e - 1) << m));
    d = 23 - m;
    k = (mn + (longint'(1) << (d - 1)) - 1 + ((mn >> d) & 1)) >> d;
    if (k == (longint'(1) << m)) begin
      k = 0;
      ne = ne + 1;
    end
    if (ne > top) return 32'(s + ((2 ** e - 1) << m));
    return 32'(s + (longint'(ne) << m) + k);
  endfunction

  function automatic logic [31:0] ref_unpack(input int code, input logic [31:0] w);
    int e, m;
    longint s, ex, mn;
    widths(code, e, m);
    if (e == 8) return w;
    s = (w >> (e + m)) & 1;
    ex = (w >> m) % (2 ** e);
    mn = w % (2 ** m);
    if (ex == 0) return 32'(s << 31);
    if (ex == 2 ** e - 1) return 32'((s << 31) + (255 << 23) + (mn << (23 - m)));
    return 32'((s << 31) + ((ex - (2 ** (e - 1) - 1) + 127) << 23) + (mn << (23 - m)));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input int code, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] ep, eu;
    fmt_i = 3'(code);
    pack_data_i = a;
    unpack_data_i = b;
    ep = ref_pack(code, a);
    eu = ref_unpack(code, b);
    @(posedge clk_i);
    #1;
    check({tag, " pack R10"}, packed_o, ep);
    check({tag, " unpack R10"}, unpacked_o, eu);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    pack_data_i = 32'h3F800000;
    unpack_data_i = 32'h3C00;
    fmt_i = 3'd4;
    repeat (3) @(posedge clk_i);
    #1;
    check("R10 reset packed", packed_o, 32'h0);
    check("R10 reset unpacked", unpacked_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    apply("R1 R3 one", 4, 32'h3F800000, 32'hFFFF3C00);
    check("R3 one half", packed_o, 32'h00003C00);
    check("R9 upper ignored", unpacked_o, 32'h3F800000);
    apply("R4 overflow", 4, 32'h47800000, 32'h00007C00);
    check("R4 inf", packed_o, 32'h00007C00);
    check("R9 inf exp", unpacked_o, 32'h7F800000);
    apply("R4 round carry", 4, 32'h477FF000, 32'h0);
    check("R4 carry inf", packed_o, 32'h00007C00);
    apply("R3 tie even down", 4, 32'h3F801000, 32'h0);
    check("R3 tie down", packed_o, 32'h00003C00);
    apply("R3 tie even up", 4, 32'h3F803000, 32'h0);
    check("R3 tie up", packed_o, 32'h00003C02);
    apply("R6 underflow", 4, 32'hB8000000, 32'h80);
    check("R6 R8 neg zero", packed_o, 32'h00008000);
    apply("R5 nan", 6, 32'h7FC00001, 32'h80);
    check("R5 quiet nan", packed_o, 32'h00000078);
    check("R9 neg zero", unpacked_o, 32'h80000000);
    apply("R4 neg inf", 5, 32'hFF800000, 32'h0);
    check("R4 R8 neg inf", packed_o, 32'h00000F80);
    apply("R2 code0", 0, 32'h12345678, 32'h9ABCDEF0);
    check("R2 pass pack", packed_o, 32'h12345678);
    check("R2 pass unpack", unpacked_o, 32'h9ABCDEF0);
    apply("R2 code7", 7, 32'hDEADBEEF, 32'h01234567);
    check("R2 pass7", packed_o, 32'hDEADBEEF);
    apply("R6 denorm in", 2, 32'h00012345, 32'h0);
    check("R6 denorm zero", packed_o, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      int code;
      logic [31:0] a, b;
      code = int'($urandom_range(0, 7));
      a = $urandom;
      if (i % 3 == 0) a[30:23] = 8'(110 + $urandom_range(0, 40));
      b = (i % 2 == 0) ? ref_pack(code, a) : $urandom;
      apply("R1 R3 R7 R9 random", code, a, b);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule